// File: doc/BRIEF.md
# Logical and funnel right shifter

This block is a 32-bit right-shift execution unit with one registered output stage. An operation selector chooses one of three shifts. The first is a logical right shift whose distance comes from a register operand. The second is a logical right shift whose distance comes from a 5-bit immediate field. The third is a funnel shift. It joins two data operands into one 64-bit value, shifts that value right and keeps only its low word.

A caller pulses `start_i` with the operands present. One cycle later the unit shows the result, a single-cycle `valid_o` pulse and four flags. `carry_o` holds the last bit shifted out of the low end. `overflow_o` is always clear. `zero_o` and `sign_o` are taken from the result. Operand fetch, decode and writeback belong to the surrounding pipeline.

Top module: `rshift_unit`

## Requirements
- R1: `valid_o` rises exactly one cycle after a cycle with `start_i` high and lasts one cycle for each start. Result and flags keep their last values while no start occurs.
- R2: `op_i` encoding is as follows. 2'b01 is a logical shift by the immediate. 2'b10 is a funnel shift. 2'b00 and 2'b11 are a logical shift by the register amount.
- R3: The register forms take the distance from `amt_reg_i[4:0]` only. Bits 31:5 have no effect on the result or the flags.
- R4: The immediate form uses `imm_i`, zero-extended, as a distance of 0 to 31.
- R5: A logical shift by s fills the top s result bits with zeros, giving `src_lo_i >> s`.
- R6: The funnel form returns the low 32 bits of `{src_hi_i, src_lo_i} >> s`, with `src_hi_i` as the high word.
- R7: For a nonzero distance s, `carry_o` equals `src_lo_i[s-1]`. For a distance of zero, the result equals `src_lo_i` and `carry_o` is 0.
- R8: `overflow_o` is 0 after every operation.
- R9: `zero_o` is 1 exactly when the result is all zeros. `sign_o` equals result bit 31.
- R10: After reset, `valid_o`, `result_o` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation this cycle |
| op_i | input | 2 | Operation select |
| amt_reg_i | input | 32 | Register holding the shift amount |
| imm_i | input | 5 | Immediate shift amount |
| src_lo_i | input | 32 | Data operand, low word of the funnel value |
| src_hi_i | input | 32 | High word of the funnel value |
| valid_o | output | 1 | Result valid pulse |
| result_o | output | 32 | Shift result |
| carry_o | output | 1 | Last bit shifted out |
| overflow_o | output | 1 | Overflow flag, always 0 |
| zero_o | output | 1 | Result is zero |
| sign_o | output | 1 | Result bit 31 |

## Verification
The carry output and the zero flag can both be set in the same cycle. This happens when the shift pushes the only set bit of the low operand out of the word, for example an operand of 1 shifted by 1, or a funnel shift with a zero high word. The sweep runs every distance against single-bit and dense operand patterns, so this case comes up in every form. In each such cycle the bench compares both flags with arithmetic references. It also checks that a nonzero high funnel word clears the zero flag while the carry stays set.

// File: rtl/rsh_pkg.sv
package rsh_pkg;
  typedef enum logic [1:0] {
    OP_SHR_REG  = 2'b00,
    OP_SHR_IMM  = 2'b01,
    OP_FUNNEL   = 2'b10,
    OP_SHR_REG2 = 2'b11
  } rsh_op_e;
endpackage

// File: rtl/rsh_amt_sel.sv
module rsh_amt_sel
  import rsh_pkg::*;
#(
  parameter int unsigned W   = 32,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic [1:0]     op_i,
  input  logic [W-1:0]   amt_reg_i,
  input  logic [SHW-1:0] imm_i,
  output logic [SHW-1:0] amt_o,
  output logic           funnel_o
);
  always_comb begin
    funnel_o = (op_i == OP_FUNNEL);
    amt_o    = (op_i == OP_SHR_IMM) ? imm_i : amt_reg_i[SHW-1:0];
  end
endmodule

// File: rtl/rsh_barrel.sv
module rsh_barrel #(
  parameter int unsigned N   = 65,
  parameter int unsigned SHW = 5
) (
  input  logic [N-1:0]   data_i,
  input  logic [SHW-1:0] amt_i,
  output logic [N-1:0]   data_o
);
  logic [N-1:0] stage [SHW+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    assign stage[k+1] = amt_i[k] ? (stage[k] >> (2**k)) : stage[k];
  end

  assign data_o = stage[SHW];
endmodule

// File: rtl/rsh_flags.sv
module rsh_flags #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] res_i,
  output logic         zero_o,
  output logic         sign_o
);
  assign zero_o = ~|res_i;
  assign sign_o = res_i[W-1];
endmodule

// File: rtl/rshift_unit.sv
module rshift_unit #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] amt_reg_i,
  input  logic [$clog2(W)-1:0] imm_i,
  input  logic [W-1:0] src_lo_i,
  input  logic [W-1:0] src_hi_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         overflow_o,
  output logic         zero_o,
  output logic         sign_o
);
  localparam int unsigned SHW = $clog2(W);
  localparam int unsigned N   = 2 * W + 1;

  logic [SHW-1:0] amt;
  logic           funnel;
  logic [N-1:0]   vec_in, vec_out;
  logic [W-1:0]   res_d;
  logic           zero_d, sign_d;

  rsh_amt_sel #(.W(W), .SHW(SHW)) u_amt (
    .op_i      (op_i),
    .amt_reg_i (amt_reg_i),
    .imm_i     (imm_i),
    .amt_o     (amt),
    .funnel_o  (funnel)
  );

  // guard bit below lsb catches the last bit shifted out
  assign vec_in = {(funnel ? src_hi_i : '0), src_lo_i, 1'b0};

  rsh_barrel #(.N(N), .SHW(SHW)) u_barrel (
    .data_i (vec_in),
    .amt_i  (amt),
    .data_o (vec_out)
  );

  assign res_d = vec_out[W:1];

  rsh_flags #(.W(W)) u_flags (
    .res_i  (res_d),
    .zero_o (zero_d),
    .sign_o (sign_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      result_o   <= '0;
      carry_o    <= 1'b0;
      overflow_o <= 1'b0;
      zero_o     <= 1'b0;
      sign_o     <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        result_o   <= res_d;
        carry_o    <= vec_out[0];
        overflow_o <= 1'b0;
        zero_o     <= zero_d;
        sign_o     <= sign_d;
      end
    end
  end
endmodule

// File: rtl/rshift_unit_chk.sv
module rshift_unit_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [1:0]   op_i,
  input logic [$clog2(W)-1:0] imm_i,
  input logic [W-1:0] src_lo_i,
  input logic         valid_o,
  input logic [W-1:0] result_o,
  input logic         carry_o,
  input logic         overflow_o,
  input logic         zero_o,
  input logic         sign_o
);
  // R1
  valid_follows_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  // R1
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  // R1
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o) && $stable(carry_o));
  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !overflow_o);
  // R9
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (zero_o == (result_o == '0)));
  // R9
  sign_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (sign_o == result_o[W-1]));
  // R7
  zero_dist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 2'b01 && imm_i == '0) |=> (result_o == $past(src_lo_i)) && !carry_o);
  // R5
  msb_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 2'b01 && imm_i != '0) |=> !result_o[W-1]);
endmodule

bind rshift_unit rshift_unit_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .op_i       (op_i),
  .imm_i      (imm_i),
  .src_lo_i   (src_lo_i),
  .valid_o    (valid_o),
  .result_o   (result_o),
  .carry_o    (carry_o),
  .overflow_o (overflow_o),
  .zero_o     (zero_o),
  .sign_o     (sign_o)
);

// File: tb/rshift_unit_bench.sv
module rshift_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [31:0] amt_reg_i = '0;
  logic [4:0]  imm_i = '0;
  logic [31:0] src_lo_i = '0;
  logic [31:0] src_hi_i = '0;
  logic        valid_o, carry_o, overflow_o, zero_o, sign_o;
  logic [31:0] result_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  rshift_unit u_rshift_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .amt_reg_i(amt_reg_i), .imm_i(imm_i), .src_lo_i(src_lo_i), .src_hi_i(src_hi_i),
    .valid_o(valid_o), .result_o(result_o), .carry_o(carry_o),
    .overflow_o(overflow_o), .zero_o(zero_o), .sign_o(sign_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // launch one op and check every output one cycle later
  task automatic run(input logic [1:0] op, input logic [31:0] amt_r, input logic [4:0] imm,
                     input logic [31:0] lo, input logic [31:0] hi);
    int s;
    logic [63:0] cat;
    logic [31:0] er;
    logic ec;
    s   = (op == 2'b01) ? int'(imm) : int'(amt_r[4:0]);
    cat = (op == 2'b10) ? {hi, lo} : {32'h0, lo};
    er  = 32'(cat >> s);
    ec  = (s == 0) ? 1'b0 : lo[s-1];
    @(negedge clk_i);
    op_i = op; amt_reg_i = amt_r; imm_i = imm; src_lo_i = lo; src_hi_i = hi;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R1 valid", 32'(valid_o), 32'd1);
    if (op == 2'b10) chk("R6 funnel result", result_o, er);
    else if (op == 2'b01) chk("R4 imm result", result_o, er);
    else chk("R3 R5 reg result", result_o, er);
    chk("R7 carry", 32'(carry_o), 32'(ec));
    chk("R8 overflow", 32'(overflow_o), 32'd0);
    chk("R9 zero", 32'(zero_o), 32'(er == 32'h0));
    chk("R9 sign", 32'(sign_o), 32'(er[31]));
  endtask

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h0000_0001; pats[1] = 32'h8000_0001; pats[2] = 32'hFFFF_FFFF;
    pats[3] = 32'hA5C3_5A3C; pats[4] = 32'h0000_0000; pats[5] = 32'h7FFF_FFFE;
    #1;
    // R10 reset state
    chk("R10 valid", 32'(valid_o), 32'd0);
    chk("R10 result", result_o, 32'd0);
    chk("R10 flags", {28'd0, carry_o, overflow_o, zero_o, sign_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int p = 0; p < 6; p++) begin
      for (int s = 0; s < 32; s++) begin
        // R4 immediate, R3/R2 register forms with junk upper bits, R6 funnel
        run(2'b01, 32'hDEAD_BEE0, 5'(s), pats[p], 32'h1234_5678);
        run(2'b00, {27'h5A5A5A5, 5'(s)}, 5'(31 - s), pats[p], 32'hFFFF_0000);
        run(2'b11, {27'h7FFFFFF, 5'(s)}, 5'd0, pats[p], 32'h0F0F_0F0F);
        run(2'b10, {27'h1234567, 5'(s)}, 5'd3, pats[p], pats[(p + 3) % 6]);
      end
    end
    // R7 carry with zero result in the same cycle
    run(2'b01, 32'h0, 5'd1, 32'h1, 32'h0);
    run(2'b10, 32'd1, 5'd0, 32'h1, 32'h0);
    run(2'b10, 32'd1, 5'd0, 32'h1, 32'h1);
    // R1 hold and single pulse
    @(negedge clk_i);
    chk("R1 pulse ends", 32'(valid_o), 32'd0);
    src_lo_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    chk("R1 hold", result_o, 32'h8000_0000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule